// File: doc/BRIEF.md
# Multi-format audio serial receiver

This block takes PCM audio for a playback path from up to three serial data lines that share one bit clock and one frame-sync line, and turns it into parallel two's-complement words. Each word comes out with a channel index and a one-cycle valid strobe. Everything runs in the system clock domain. In slave mode the incoming bit clock, frame sync and data are synchronised and sampled on the detected rising bit-clock edge. In master mode the block divides the system clock down to make its own bit clock and frame sync.

The framing is chosen at run time with a 2-bit format field: right-justified, left-justified, I2S, or a six-channel time-division mode that uses only the first data line. A 2-bit resolution field sets the sample length, and a slot-width input sets 24 or 32 bit clocks per slot in the two-channel modes. Each data line has its own output lane. All three lanes can therefore present a sample in the same system clock cycle.

Top module: `pcm_serial_rx`

## Requirements
- R1: With masterMode=1, bckOut is a square wave with a period of 2*BCK_HALF system clocks, and fsOut changes only in the cycle where bckOut falls. With masterMode=0, both outputs are held low.
- R2: In master mode, bit b of a frame (counting from 0) is sent with fsOut at these levels. Right-justified and left-justified: high for b < W and low for the right slot. I2S: high for W-1 <= b <= 2W-2 and low otherwise. TDM: high only for b = 0. W is the slot length, and a frame holds 2 slots, or 6 slots in TDM.
- R3: resSel encodes the sample length N: 00 = 16, 01 = 20, 10 = 24, 11 = 32. fmtSel encodes the framing: 00 = right-justified, 01 = left-justified, 10 = I2S, 11 = TDM.
- R4: Outside TDM, slotWide=0 gives W = 24 and slotWide=1 gives W = 32 bit clocks per slot. If N exceeds W, N is clipped to W.
- R5: Left-justified: the MSB is the bit sampled at the first rising bit-clock edge that sees the new frame-sync level. Frame sync high marks the left slot.
- R6: I2S: the MSB is sampled one bit clock after the edge that first sees the frame-sync change. Frame sync low marks the left slot.
- R7: Right-justified: the LSB is the last bit of the slot, and the W-N leading bits of the slot are ignored.
- R8: In left-justified, I2S and TDM modes, the slot bits after the first N are ignored.
- R9: TDM: a one-bit-clock high pulse on frame sync marks channel 0. Six slots of W = N bits follow on sdIn[0] and carry channels 0 to 5 in order. Lanes 1 and 2 produce no samples.
- R10: Each sample is output MSB-first-assembled and sign-extended from N to 32 bits, with valid high for one system clock. The channel index is 2*lane + (1 for the right slot), or the slot number in TDM. The lanes are independent, so several can be valid in the same cycle.
- R11: In slave mode, data and frame sync are taken at the rising edges of bckIn. Inputs change while bckIn is low, and each bckIn phase lasts at least 3 system clocks.
- R12: During reset, sampleValid is 0 and bckOut is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| masterMode | input | 1 | 1 = block drives bit clock and frame sync |
| fmtSel | input | 2 | Framing select |
| resSel | input | 2 | Sample length select |
| slotWide | input | 1 | Slot width select for the two-channel modes |
| bckIn | input | 1 | Bit clock in slave mode |
| fsIn | input | 1 | Frame sync in slave mode |
| sdIn | input | LANES | Serial data lines |
| bckOut | output | 1 | Bit clock in master mode |
| fsOut | output | 1 | Frame sync in master mode |
| sampleValid | output | LANES | Per-lane one-cycle sample strobe |
| sampleChan | output | 3*LANES | Per-lane channel index |
| sampleData | output | 32*LANES | Per-lane sign-extended sample |

## Verification
The last bit of a left or right slot ends in the same bit-clock tick on all three lanes, so three samples complete together. The two-channel tests drive different values on every lane and expect `sampleValid` to read 3'b111 in at least one cycle. Each lane is compared against its own expected queue, so a dropped or merged lane shows up as a mismatch.

In I2S mode, the frame-sync edge that starts a slot also falls on the final bit of the previous slot. The bench checks that this bit still completes the old sample while the new slot begins one tick later.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

  typedef enum logic [1:0] {
    FMT_RJ  = 2'b00,
    FMT_LJ  = 2'b01,
    FMT_I2S = 2'b10,
    FMT_TDM = 2'b11
  } fmt_e;

  localparam int TDM_SLOTS = 6;

  // Strobes from the frame control to the lane datapath
  typedef struct packed {
    logic       capture;
    logic       complete;
    logic       rightSide;
    logic       tdm;
    logic [2:0] slotIdx;
  } rxStrobe_t;

  function automatic logic [5:0] resToBits(input logic [1:0] code);
    case (code)
      2'b00:   return 6'd16;
      2'b01:   return 6'd20;
      2'b10:   return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

  function automatic logic [31:0] signExt(input logic [31:0] x, input logic [5:0] len);
    logic [31:0] r;
    logic [5:0]  msb;
    msb = len - 6'd1;
    for (int i = 0; i < 32; i++) r[i] = (i < int'(len)) ? x[i] : x[msb[4:0]];
    return r;
  endfunction

endpackage

// File: rtl/pcm_rx_clkgen.sv
module pcm_rx_clkgen
  import pcm_rx_pkg::*;
#(
  parameter int LANES    = 3,
  parameter int BCK_HALF = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             masterMode,
  input  fmt_e             fmt,
  input  logic [5:0]       slotLen,
  input  logic             bckIn,
  input  logic             fsIn,
  input  logic [LANES-1:0] sdIn,
  output logic             bitTick,
  output logic             fsBit,
  output logic [LANES-1:0] sdBits,
  output logic             bckOut,
  output logic             fsOut
);
  localparam int DIV_W = (BCK_HALF > 1) ? $clog2(BCK_HALF) : 1;

  logic [DIV_W-1:0] divCnt;
  logic             divWrap, bckReg, fsMaster;
  logic [7:0]       mpos, frameBits;
  logic [1:0]       bckSync, fsSync;
  logic             bckPrev;
  logic [LANES-1:0] sdSync0, sdSync1;

  assign divWrap   = (divCnt == DIV_W'(BCK_HALF - 1));
  assign frameBits = (fmt == FMT_TDM) ? 8'(slotLen) * 8'd6 : {1'b0, slotLen, 1'b0};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
      bckReg <= 1'b0;
      mpos   <= '0;
    end else begin
      divCnt <= divWrap ? '0 : divCnt + 1'b1;
      if (divWrap) begin
        bckReg <= ~bckReg;
        if (bckReg) mpos <= (mpos >= frameBits - 8'd1) ? 8'd0 : mpos + 8'd1;
      end
    end
  end

  always_comb begin
    case (fmt)
      FMT_TDM: fsMaster = (mpos == 8'd0);
      FMT_I2S: fsMaster = (mpos >= 8'(slotLen) - 8'd1) && (mpos <= {1'b0, slotLen, 1'b0} - 8'd2);
      default: fsMaster = (mpos < 8'(slotLen));
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bckSync <= '0;
      fsSync  <= '0;
      bckPrev <= 1'b0;
      sdSync0 <= '0;
      sdSync1 <= '0;
    end else begin
      bckSync <= {bckSync[0], bckIn};
      fsSync  <= {fsSync[0], fsIn};
      bckPrev <= bckSync[1];
      sdSync0 <= sdIn;
      sdSync1 <= sdSync0;
    end
  end

  assign bitTick = masterMode ? (divWrap && !bckReg) : (bckSync[1] && !bckPrev);
  assign fsBit   = masterMode ? fsMaster : fsSync[1];
  assign sdBits  = sdSync1;
  assign bckOut  = masterMode & bckReg;
  assign fsOut   = masterMode & fsMaster;

  // R1: master frame sync only moves together with a falling bit clock
  assert_fs_on_fall_R1: assert property (@(posedge clk) disable iff (!rstN)
    masterMode && $stable(masterMode) && $stable(fmt) && $stable(slotLen) && !$stable(fsOut)
      |-> $fell(bckOut));

endmodule

// File: rtl/pcm_rx_ctrl.sv
module pcm_rx_ctrl
  import pcm_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitTick,
  input  logic       fsBit,
  input  fmt_e       fmt,
  input  logic [5:0] slotLen,
  input  logic [5:0] dataLen,
  output rxStrobe_t  strobe
);
  logic       fsPrev, pendI2S, actReg, rightReg;
  logic [5:0] posReg;
  logic [2:0] slotReg;

  logic       edgeSeen, start, curAct, curRight, inWindow, lastBit;
  logic [5:0] curPos;
  logic [2:0] curSlot;

  assign edgeSeen = (fmt == FMT_TDM) ? (fsBit & ~fsPrev) : (fsBit ^ fsPrev);
  assign start    = (fmt == FMT_I2S) ? pendI2S : edgeSeen;
  assign curRight = start ? ((fmt == FMT_I2S) ? fsBit : ~fsBit) : rightReg;

  always_comb begin
    curAct  = 1'b0;
    curPos  = posReg;
    curSlot = slotReg;
    if (start) begin
      curAct  = 1'b1;
      curPos  = '0;
      curSlot = '0;
    end else if (actReg) begin
      if (posReg == slotLen - 6'd1) begin
        if (fmt == FMT_TDM && slotReg < 3'(TDM_SLOTS - 1)) begin
          curAct  = 1'b1;
          curPos  = '0;
          curSlot = slotReg + 3'd1;
        end
      end else begin
        curAct = 1'b1;
        curPos = posReg + 6'd1;
      end
    end
  end

  always_comb begin
    if (fmt == FMT_RJ) begin
      inWindow = (curPos >= slotLen - dataLen);
      lastBit  = (curPos == slotLen - 6'd1);
    end else begin
      inWindow = (curPos < dataLen);
      lastBit  = (curPos == dataLen - 6'd1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fsPrev   <= 1'b0;
      pendI2S  <= 1'b0;
      actReg   <= 1'b0;
      rightReg <= 1'b0;
      posReg   <= '0;
      slotReg  <= '0;
    end else if (bitTick) begin
      fsPrev   <= fsBit;
      pendI2S  <= edgeSeen && (fmt == FMT_I2S);
      actReg   <= curAct;
      rightReg <= curRight;
      posReg   <= curPos;
      slotReg  <= curSlot;
    end
  end

  assign strobe.capture   = bitTick & curAct & inWindow;
  assign strobe.complete  = bitTick & curAct & lastBit;
  assign strobe.rightSide = curRight;
  assign strobe.tdm       = (fmt == FMT_TDM);
  assign strobe.slotIdx   = curSlot;

  // R8: a sample only finishes on a bit that is also taken into the word
  assert_complete_captures_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.complete |-> strobe.capture);

  // R9: time-division slot index stays within the six channels
  assert_tdm_slot_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture && strobe.tdm |-> strobe.slotIdx < 3'(TDM_SLOTS));

endmodule

// File: rtl/pcm_rx_datapath.sv
module pcm_rx_datapath
  import pcm_rx_pkg::*;
#(
  parameter int LANES = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  rxStrobe_t          strobe,
  input  logic [LANES-1:0]   sdBits,
  input  logic [5:0]         dataLen,
  output logic [LANES-1:0]   sampleValid,
  output logic [LANES*3-1:0] sampleChan,
  output logic [LANES*32-1:0] sampleData
);
  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    logic        laneOn, validR;
    logic [31:0] shiftReg, shiftNext, dataR;
    logic [2:0]  chanR;

    assign laneOn    = (lane == 0) || !strobe.tdm;
    assign shiftNext = {shiftReg[30:0], sdBits[lane]};

    always_ff @(posedge clk) begin
      if (!rstN) begin
        shiftReg <= '0;
        validR   <= 1'b0;
        dataR    <= '0;
        chanR    <= '0;
      end else begin
        if (strobe.capture && laneOn) shiftReg <= shiftNext;
        validR <= strobe.complete && laneOn;
        if (strobe.complete && laneOn) begin
          dataR <= signExt(shiftNext, dataLen);
          chanR <= strobe.tdm ? strobe.slotIdx : 3'(lane * 2) + {2'b00, strobe.rightSide};
        end
      end
    end

    assign sampleValid[lane]          = validR;
    assign sampleChan[lane*3 +: 3]    = chanR;
    assign sampleData[lane*32 +: 32]  = dataR;

    // R10: strobe lasts one system clock
    assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
      validR |=> !validR);

    // R10: bits above the sample length copy its sign bit
    assert_sign_ext_R10: assert property (@(posedge clk) disable iff (!rstN)
      validR && $stable(dataLen) |-> ((dataR ^ {32{dataR[31]}}) >> (dataLen - 6'd1)) == 32'd0);

    if (lane > 0) begin : g_quiet
      // R9: upper lanes stay silent in time-division mode
      assert_tdm_lane_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
        strobe.tdm && $past(strobe.tdm) |-> !validR);
    end
  end

endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
  import pcm_rx_pkg::*;
#(
  parameter int LANES    = 3,
  parameter int BCK_HALF = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                masterMode,
  input  logic [1:0]          fmtSel,
  input  logic [1:0]          resSel,
  input  logic                slotWide,
  input  logic                bckIn,
  input  logic                fsIn,
  input  logic [LANES-1:0]    sdIn,
  output logic                bckOut,
  output logic                fsOut,
  output logic [LANES-1:0]    sampleValid,
  output logic [LANES*3-1:0]  sampleChan,
  output logic [LANES*32-1:0] sampleData
);
  fmt_e             fmt;
  logic [5:0]       resBits, slotLen, dataLen;
  logic             bitTick, fsBit;
  logic [LANES-1:0] sdBits;
  rxStrobe_t        strobe;

  assign fmt     = fmt_e'(fmtSel);
  assign resBits = resToBits(resSel);
  assign slotLen = (fmt == FMT_TDM) ? resBits : (slotWide ? 6'd32 : 6'd24);
  assign dataLen = (resBits > slotLen) ? slotLen : resBits;

  pcm_rx_clkgen #(.LANES(LANES), .BCK_HALF(BCK_HALF)) u_clkgen (
    .clk(clk), .rstN(rstN), .masterMode(masterMode), .fmt(fmt), .slotLen(slotLen),
    .bckIn(bckIn), .fsIn(fsIn), .sdIn(sdIn),
    .bitTick(bitTick), .fsBit(fsBit), .sdBits(sdBits), .bckOut(bckOut), .fsOut(fsOut)
  );

  pcm_rx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .fsBit(fsBit), .fmt(fmt),
    .slotLen(slotLen), .dataLen(dataLen), .strobe(strobe)
  );

  pcm_rx_datapath #(.LANES(LANES)) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdBits(sdBits), .dataLen(dataLen),
    .sampleValid(sampleValid), .sampleChan(sampleChan), .sampleData(sampleData)
  );

endmodule

// File: tb/pcm_serial_rx_bench.sv
module pcm_serial_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LANES      = 3;
  localparam int BCK_HALF   = 4;
  localparam int SLV_HALF   = 8;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                masterMode = 1'b0;
  logic [1:0]          fmtSel = 2'b10;
  logic [1:0]          resSel = 2'b10;
  logic                slotWide = 1'b0;
  logic                bckIn = 1'b0;
  logic                fsIn = 1'b0;
  logic [LANES-1:0]    sdIn = '0;
  logic                bckOut, fsOut;
  logic [LANES-1:0]    sampleValid;
  logic [LANES*3-1:0]  sampleChan;
  logic [LANES*32-1:0] sampleData;

  int    errors = 0;
  int    checks = 0;
  int    cyc = 0;
  bit    armed = 0;
  bit    done = 0;
  bit    sawTriple = 0;
  string curTag = "R5";
  int    curFmt, curW, curN;
  bit    curTdm;
  logic [34:0] q0[$], q1[$], q2[$];

  pcm_serial_rx #(.LANES(LANES), .BCK_HALF(BCK_HALF)) u_pcm_serial_rx (
    .clk(clk), .rstN(rstN), .masterMode(masterMode), .fmtSel(fmtSel), .resSel(resSel),
    .slotWide(slotWide), .bckIn(bckIn), .fsIn(fsIn), .sdIn(sdIn),
    .bckOut(bckOut), .fsOut(fsOut), .sampleValid(sampleValid),
    .sampleChan(sampleChan), .sampleData(sampleData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] maskN(int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction

  function automatic logic [31:0] slotVal(int f, int l, int s, int n);
    logic [31:0] h;
    h = 32'(f * 7919 + l * 104729 + s * 31337 + 17) * 32'h9E37_79B1;
    h = h ^ (h >> 13);
    if (f == 1 && s == 0) h = 32'd1 << (n - 1);               // most negative
    if (f == 1 && s == 1) h = (32'd1 << (n - 1)) - 32'd1;     // most positive
    return h & maskN(n);
  endfunction

  function automatic logic [31:0] sx(logic [31:0] v, int n);
    return v[n-1] ? (v | ~maskN(n)) : v;
  endfunction

  // R2: expected frame-sync level per frame bit
  function automatic logic fsExp(int b);
    case (curFmt)
      3:       return b == 0;
      2:       return (b >= curW - 1) && (b <= 2 * curW - 2);
      default: return b < curW;
    endcase
  endfunction

  function automatic logic sdBitFor(int f, int b, int l);
    int s, p;
    logic [31:0] v;
    s = b / curW;
    p = b % curW;
    if (curTdm && l > 0) return 1'($urandom);
    v = slotVal(f, l, s, curN);
    if (curFmt == 0) return (p >= curW - curN) ? v[curW-1-p] : 1'($urandom);
    return (p < curN) ? v[curN-1-p] : 1'($urandom);
  endfunction

  task automatic fail(string tag, string what, longint act, longint exp);
    errors++;
    $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
  endtask

  task automatic checkLane(int l);
    logic [34:0] act, e;
    int sz;
    act = {sampleChan[l*3 +: 3], sampleData[l*32 +: 32]};
    sz = (l == 0) ? q0.size() : (l == 1) ? q1.size() : q2.size();
    checks++;
    if (sz == 0) begin
      fail(curTag, $sformatf("unexpected sample lane %0d", l), longint'(act), 0);
      return;
    end
    if (l == 0) e = q0.pop_front(); else if (l == 1) e = q1.pop_front(); else e = q2.pop_front();
    // R10: chan in bits 34:32, sign-extended word below
    if (act !== e) fail(curTag, $sformatf("lane %0d chan/data", l), longint'(act), longint'(e));
  endtask

  always @(negedge clk) begin
    if (rstN && armed) begin
      if (sampleValid == 3'b111) sawTriple = 1;
      for (int l = 0; l < LANES; l++) if (sampleValid[l]) checkLane(l);
    end
  end

  task automatic driveBit(int f, int b);
    fsIn = masterMode ? 1'b0 : fsExp(b);
    for (int l = 0; l < LANES; l++) sdIn[l] = sdBitFor(f, b, l);
  endtask

  task automatic runTest(bit mst, int fmt, int res, bit wide, int nFr, string tag);
    int nBits, slots, fb, lastNeg;
    logic [34:0] e;
    nBits  = (res == 0) ? 16 : (res == 1) ? 20 : (res == 2) ? 24 : 32;
    curTdm = (fmt == 3);
    curFmt = fmt;
    curW   = curTdm ? nBits : (wide ? 32 : 24);
    curN   = (nBits > curW) ? curW : nBits;
    slots  = curTdm ? 6 : 2;
    fb     = curW * slots;
    curTag = tag;
    armed  = 0;
    rstN = 0; masterMode = mst; fmtSel = 2'(fmt); resSel = 2'(res); slotWide = wide;
    bckIn = 0; fsIn = 0;
    for (int f = 1; f <= nFr; f++)
      for (int s = 0; s < slots; s++)
        for (int l = 0; l < LANES; l++)
          if (!curTdm || l == 0) begin
            e = {3'(curTdm ? s : 2 * l + s), sx(slotVal(f, l, s, curN), curN)};
            if (l == 0) q0.push_back(e); else if (l == 1) q1.push_back(e); else q2.push_back(e);
          end
    driveBit(0, 0);
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    lastNeg = 0;
    for (int f = 0; f <= nFr; f++) begin
      for (int b = 0; b < fb; b++) begin
        if (mst) begin
          if (!(f == 0 && b == 0)) begin
            @(negedge bckOut);
            if (f == 0 && b == 3) begin
              checks++;   // R1: bit clock period
              if (cyc - lastNeg != 2 * BCK_HALF) fail("R1", "bck period", cyc - lastNeg, 2 * BCK_HALF);
            end
            lastNeg = cyc;
            #1;
          end
          driveBit(f, b);
          checks++;     // R2: master frame-sync pattern
          if (fsOut !== fsExp(b)) fail("R2", $sformatf("fsOut frame %0d bit %0d", f, b), fsOut, fsExp(b));
          if (f == 1 && b == 0) armed = 1;
        end else begin
          driveBit(f, b);
          if (f == 1 && b == 0) armed = 1;
          if (f == 0 && b == 1) begin
            checks++;   // R1: outputs held low in slave mode
            if (bckOut !== 1'b0 || fsOut !== 1'b0) fail("R1", "slave outputs", {bckOut, fsOut}, 0);
          end
          repeat (SLV_HALF) @(posedge clk);
          #1 bckIn = 1;
          repeat (SLV_HALF) @(posedge clk);
          #1 bckIn = 0;
        end
      end
    end
    repeat (4 * BCK_HALF + 8) @(posedge clk);
    #1;
    checks++;
    if (q0.size() + q1.size() + q2.size() != 0)
      fail(tag, "samples missing", q0.size() + q1.size() + q2.size(), 0);
    armed = 0;
    q0.delete(); q1.delete(); q2.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;   // R12: reset state
    if (sampleValid !== '0 || bckOut !== 1'b0) fail("R12", "reset outputs", {sampleValid, bckOut}, 0);

    runTest(1, 1, 2, 0, 3, "R5");    // left-justified, master, N=24 W=24
    checks++;   // R10: all lanes strobed together
    if (!sawTriple) fail("R10", "three lanes in one cycle", 0, 1);
    runTest(1, 2, 2, 1, 3, "R6");    // I2S master, N=24 in W=32: trailing bits ignored (R8)
    runTest(0, 0, 0, 1, 3, "R7");    // right-justified slave, 16 leading junk bits (R11)
    runTest(1, 0, 3, 0, 3, "R4");    // right-justified, N=32 clipped to W=24
    runTest(0, 1, 1, 0, 3, "R8");    // left-justified slave, N=20 (R3 code 01)
    runTest(0, 2, 3, 1, 3, "R11");   // I2S slave, N=32
    runTest(1, 3, 0, 0, 3, "R9");    // time-division master, N=16
    runTest(0, 3, 3, 0, 2, "R3");    // time-division slave, N=32 (code 11)

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule